// File: doc/BRIEF.md
# Board Control Register Window with Line-Clock Rate Select

This block is a small window of four 16-bit board registers reached over a simple single-cycle register bus. Bits 2:1 of the access address pick one of four slots: a control/status word, a page control word, a configuration/display slot and an auxiliary status word. Bit 0 of the address names the byte lane of a byte write. Slots that a build leaves out, as set by a parameter, answer reads with zero and raise a non-existent-memory flag.

The control/status word drives the line-time-clock controls of the board. Two of its bits force the clock's interrupt enable and force its register to answer as non-existent. A 2-bit field selects the tick rate in ticks per second through a fixed table, and code 0 falls back to a default rate set by a parameter. The configuration/display slot reads the board switches through a mask, and writes to it load a display register that drives an output.

Reads are combinational in the access cycle. Writes take effect at the clock edge, so the stored values and every output derived from them change on the cycle after the write.

Top module: `brdctl_window`

## Requirements
- R1: Address bits 2:1 select the slot: 0 control/status, 1 page control, 2 configuration/display, 3 auxiliary status. A slot whose bit in SLOT_EN is clear returns zero on read with `nxm` high, and writes to it are ignored. An implemented slot gives `nxm` low, and `rdata` is zero whenever `acc_en` is low.
- R2: A word write to the control/status slot changes only the bits set in CSR_WMASK (default 16'h3F0F); every other bit keeps its previous value. A read returns the whole stored word.
- R3: Byte data travels on `wdata[7:0]`. A byte write to the control/status, page control or auxiliary slot replaces the high lane when address bit 0 is 1 and the low lane when it is 0. The other lane keeps its stored value, and the register's own mask is then applied.
- R4: From the cycle after any control/status write, `clk_force_ie` equals bit 10 of that register and `clk_force_nxm` equals bit 11.
- R5: Bits 13:12 of the control/status word select `tick_rate`: 1 gives 60, 2 gives 50 and 3 gives 800. Code 0 gives DEF_RATE (default 100). The value is 10-bit binary and valid on the cycle after the write.
- R6: A read of the configuration/display slot returns `sw_in` ANDed with SW_RMASK (default 16'h0FF0).
- R7: A write to the configuration/display slot loads `display_out` with DISP_MASK (default 16'hFF0F) ANDed with: `wdata` for a word write, {8'h00, wdata[7:0]} for an even byte write, and {wdata[7:0], 8'h00} for an odd byte write.
- R8: A word write stores `wdata` ANDed with PAGE_MASK (default 16'h7FFF) in the page control slot, and ANDed with AUX_MASK (default 16'hFF0F) in the auxiliary slot.
- R9: Reset clears the control/status, page, auxiliary and display registers. It sets `tick_rate` to DEF_RATE and both force outputs low.
- R10: A read changes no stored value and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Register access in this cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_byte | input | 1 | 1 for a byte write, 0 for a word write |
| acc_addr | input | 3 | Bits 2:1 select the slot, bit 0 selects the byte lane |
| wdata | input | 16 | Write data; byte data on bits 7:0 |
| rdata | output | 16 | Read data, combinational |
| nxm | output | 1 | Access to an unimplemented slot |
| sw_in | input | 16 | Board switch inputs |
| display_out | output | 16 | Display register |
| clk_force_ie | output | 1 | Force line-clock interrupt enable |
| clk_force_nxm | output | 1 | Force line-clock register non-existent |
| tick_rate | output | 10 | Selected line-clock ticks per second |

## Verification
The bench targets the lane handling of byte writes. A design that shifted odd bytes into the merged registers, or that merged into the display register instead of clearing the other lane, shows wrong readback or a wrong `display_out`. It also writes all ones, and then only non-writable bits, to the control/status word; a design that ignored CSR_WMASK, or cleared the protected bits, reads back a different word. The bench walks the rate field through all four codes, so a swapped table entry or a stuck default shows on `tick_rate`. A second instance with two slots left out checks that those slots read zero with `nxm`, not stale register data.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int BUS_W      = 16;
  localparam int RATE_W     = 10;
  localparam int LANE_W     = 8;
  localparam int FIE_BIT    = 10;
  localparam int FNXM_BIT   = 11;
  localparam int SEL_LO     = 12;
  localparam int NUM_SLOTS  = 4;

  typedef enum logic [1:0] {
    SLOT_CSR  = 2'd0,
    SLOT_PAGE = 2'd1,
    SLOT_CFG  = 2'd2,
    SLOT_AUX  = 2'd3
  } slot_e;

  // Replace one byte lane of the stored word; byte data sits on the low lane.
  function automatic logic [BUS_W-1:0] lane_merge(
    input logic [BUS_W-1:0] old_v,
    input logic [BUS_W-1:0] wd,
    input logic             is_byte,
    input logic             hi_lane
  );
    logic [BUS_W-1:0] r;
    if (!is_byte)     r = wd;
    else if (hi_lane) r = {wd[LANE_W-1:0], old_v[LANE_W-1:0]};
    else              r = {old_v[BUS_W-1:LANE_W], wd[LANE_W-1:0]};
    return r;
  endfunction

  // Place write data without merging: odd bytes move up one lane.
  function automatic logic [BUS_W-1:0] lane_align(
    input logic [BUS_W-1:0] wd,
    input logic             is_byte,
    input logic             hi_lane
  );
    logic [BUS_W-1:0] r;
    if (!is_byte)     r = wd;
    else if (hi_lane) r = {wd[LANE_W-1:0], {LANE_W{1'b0}}};
    else              r = {{LANE_W{1'b0}}, wd[LANE_W-1:0]};
    return r;
  endfunction

  function automatic logic [RATE_W-1:0] rate_of(
    input logic [1:0]        sel,
    input logic [RATE_W-1:0] dflt
  );
    logic [RATE_W-1:0] r;
    case (sel)
      2'd1:    r = RATE_W'(60);
      2'd2:    r = RATE_W'(50);
      2'd3:    r = RATE_W'(800);
      default: r = dflt;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/brd_decode.sv
module brd_decode
  import brd_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] SLOT_EN = 4'b1111
) (
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [1:0]           slot_sel,
  output slot_e                slot,
  output logic                 slot_ok,
  output logic                 nxm,
  output logic [NUM_SLOTS-1:0] wr_evt
);
  assign slot    = slot_e'(slot_sel);
  assign slot_ok = SLOT_EN[slot_sel];
  assign nxm     = acc_en && !slot_ok;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_strobe
    if (SLOT_EN[i]) begin : g_on
      assign wr_evt[i] = acc_en && acc_wr && (slot_sel == i[1:0]);
    end else begin : g_off
      assign wr_evt[i] = 1'b0;
    end
  end
endmodule

// File: rtl/brd_csr.sv
module brd_csr
  import brd_pkg::*;
#(
  parameter logic [BUS_W-1:0]  WMASK    = 16'h3F0F,
  parameter logic [RATE_W-1:0] DEF_RATE = 10'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              is_byte,
  input  logic              hi_lane,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  csr_q,
  output logic              force_ie,
  output logic              force_nxm,
  output logic [RATE_W-1:0] tick_rate
);
  logic [BUS_W-1:0] merged;
  logic [BUS_W-1:0] csr_next;

  assign merged   = lane_merge(csr_q, wdata, is_byte, hi_lane);
  assign csr_next = (csr_q & ~WMASK) | (merged & WMASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q     <= '0;
      tick_rate <= DEF_RATE;
    end else if (wr) begin
      csr_q     <= csr_next;
      tick_rate <= rate_of(csr_next[SEL_LO+1:SEL_LO], DEF_RATE);
    end
  end

  assign force_ie  = csr_q[FIE_BIT];
  assign force_nxm = csr_q[FNXM_BIT];
endmodule

// File: rtl/brd_mreg.sv
module brd_mreg
  import brd_pkg::*;
#(
  parameter logic [BUS_W-1:0] MASK  = 16'hFFFF,
  parameter bit               ALIGN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             is_byte,
  input  logic             hi_lane,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] q
);
  logic [BUS_W-1:0] placed;

  if (ALIGN) begin : g_align
    assign placed = lane_align(wdata, is_byte, hi_lane);
  end else begin : g_merge
    assign placed = lane_merge(q, wdata, is_byte, hi_lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= placed & MASK;
  end
endmodule

// File: rtl/brdctl_window.sv
module brdctl_window
  import brd_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] SLOT_EN   = 4'b1111,
  parameter logic [BUS_W-1:0]     CSR_WMASK = 16'h3F0F,
  parameter logic [BUS_W-1:0]     PAGE_MASK = 16'h7FFF,
  parameter logic [BUS_W-1:0]     AUX_MASK  = 16'hFF0F,
  parameter logic [BUS_W-1:0]     SW_RMASK  = 16'h0FF0,
  parameter logic [BUS_W-1:0]     DISP_MASK = 16'hFF0F,
  parameter logic [RATE_W-1:0]    DEF_RATE  = 10'd100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_byte,
  input  logic [2:0]        acc_addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              nxm,
  input  logic [BUS_W-1:0]  sw_in,
  output logic [BUS_W-1:0]  display_out,
  output logic              clk_force_ie,
  output logic              clk_force_nxm,
  output logic [RATE_W-1:0] tick_rate
);
  slot_e                slot;
  logic                 slot_ok;
  logic [NUM_SLOTS-1:0] wr_evt;
  logic                 hi_lane;
  logic [BUS_W-1:0]     csr_q, page_q, aux_q;

  assign hi_lane = acc_addr[0];

  brd_decode #(.SLOT_EN(SLOT_EN)) u_dec (
    .acc_en(acc_en), .acc_wr(acc_wr), .slot_sel(acc_addr[2:1]),
    .slot(slot), .slot_ok(slot_ok), .nxm(nxm), .wr_evt(wr_evt)
  );

  brd_csr #(.WMASK(CSR_WMASK), .DEF_RATE(DEF_RATE)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr(wr_evt[SLOT_CSR]), .is_byte(acc_byte),
    .hi_lane(hi_lane), .wdata(wdata), .csr_q(csr_q),
    .force_ie(clk_force_ie), .force_nxm(clk_force_nxm), .tick_rate(tick_rate)
  );

  brd_mreg #(.MASK(PAGE_MASK), .ALIGN(1'b0)) u_page (
    .clk(clk), .rst_n(rst_n), .wr(wr_evt[SLOT_PAGE]), .is_byte(acc_byte),
    .hi_lane(hi_lane), .wdata(wdata), .q(page_q)
  );

  brd_mreg #(.MASK(AUX_MASK), .ALIGN(1'b0)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr(wr_evt[SLOT_AUX]), .is_byte(acc_byte),
    .hi_lane(hi_lane), .wdata(wdata), .q(aux_q)
  );

  brd_mreg #(.MASK(DISP_MASK), .ALIGN(1'b1)) u_disp (
    .clk(clk), .rst_n(rst_n), .wr(wr_evt[SLOT_CFG]), .is_byte(acc_byte),
    .hi_lane(hi_lane), .wdata(wdata), .q(display_out)
  );

  always_comb begin
    rdata = '0;
    if (acc_en && slot_ok) begin
      case (slot)
        SLOT_CSR:  rdata = csr_q;
        SLOT_PAGE: rdata = page_q;
        SLOT_CFG:  rdata = sw_in & SW_RMASK;
        SLOT_AUX:  rdata = aux_q;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/brd_chk.sv
module brd_chk
  import brd_pkg::*;
#(
  parameter logic [NUM_SLOTS-1:0] SLOT_EN  = 4'b1111,
  parameter logic [RATE_W-1:0]    DEF_RATE = 10'd100
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_en,
  input logic                 acc_wr,
  input logic [2:0]           acc_addr,
  input logic [BUS_W-1:0]     rdata,
  input logic                 nxm,
  input logic [BUS_W-1:0]     display_out,
  input logic                 clk_force_ie,
  input logic                 clk_force_nxm,
  input logic [RATE_W-1:0]    tick_rate,
  input logic [NUM_SLOTS-1:0] wr_evt
);
  // R1
  missing_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !SLOT_EN[acc_addr[2:1]]) |-> (nxm && rdata == '0));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (rdata == '0 && !nxm));

  // R1
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_evt) && ((wr_evt & ~SLOT_EN) == '0));

  // R4
  force_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt[SLOT_CSR] |=> ($stable(clk_force_ie) && $stable(clk_force_nxm)));

  // R5
  rate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_rate == RATE_W'(60)) || (tick_rate == RATE_W'(50)) ||
    (tick_rate == RATE_W'(800)) || (tick_rate == DEF_RATE));

  // R7
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt[SLOT_CFG] |=> $stable(display_out));

  // R10
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> ($stable(tick_rate) && $stable(display_out)));
endmodule

bind brdctl_window brd_chk #(.SLOT_EN(SLOT_EN), .DEF_RATE(DEF_RATE)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .rdata(rdata), .nxm(nxm), .display_out(display_out),
  .clk_force_ie(clk_force_ie), .clk_force_nxm(clk_force_nxm),
  .tick_rate(tick_rate), .wr_evt(wr_evt)
);

// File: tb/sim_brdctl_window.sv
`timescale 1ns/1ps
module sim_brdctl_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_byte = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [15:0] wdata = '0, sw_in = 16'hA5C3;
  logic [15:0] rdata, display_out, rdata1, display1;
  logic        nxm, fie, fnxm, nxm1, fie1, fnxm1;
  logic [9:0]  tick_rate, tick1;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  brdctl_window u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata),
    .nxm(nxm), .sw_in(sw_in), .display_out(display_out),
    .clk_force_ie(fie), .clk_force_nxm(fnxm), .tick_rate(tick_rate)
  );

  // Slots 1 and 3 left out.
  brdctl_window #(.SLOT_EN(4'b0101)) u1 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .wdata(wdata), .rdata(rdata1),
    .nxm(nxm1), .sw_in(sw_in), .display_out(display1),
    .clk_force_ie(fie1), .clk_force_nxm(fnxm1), .tick_rate(tick1)
  );

  // {byte, addr, wdata, exp readback, exp tick, exp fie, exp fnxm, exp display}
  localparam logic [63:0] VEC [14] = '{
    {1'b0, 3'd0, 16'hFFFF, 16'h3F0F, 10'd800, 1'b1, 1'b1, 16'h0000}, // R2 R5
    {1'b1, 3'd0, 16'hFF00, 16'h3F00, 10'd800, 1'b1, 1'b1, 16'h0000}, // R3 low lane
    {1'b1, 3'd1, 16'h0012, 16'h1200, 10'd60,  1'b0, 1'b0, 16'h0000}, // R3 high lane
    {1'b0, 3'd0, 16'h2C05, 16'h2C05, 10'd50,  1'b1, 1'b1, 16'h0000}, // R4 R5
    {1'b0, 3'd0, 16'h0000, 16'h0000, 10'd100, 1'b0, 1'b0, 16'h0000}, // R5 default
    {1'b0, 3'd2, 16'hFFFF, 16'h7FFF, 10'd100, 1'b0, 1'b0, 16'h0000}, // R8 page
    {1'b1, 3'd3, 16'h0080, 16'h00FF, 10'd100, 1'b0, 1'b0, 16'h0000}, // R3 page hi
    {1'b1, 3'd2, 16'h0034, 16'h0034, 10'd100, 1'b0, 1'b0, 16'h0000}, // R3 page lo
    {1'b0, 3'd6, 16'h1234, 16'h1204, 10'd100, 1'b0, 1'b0, 16'h0000}, // R8 aux
    {1'b1, 3'd7, 16'h00AB, 16'hAB04, 10'd100, 1'b0, 1'b0, 16'h0000}, // R3 aux hi
    {1'b0, 3'd4, 16'h1234, 16'h05C0, 10'd100, 1'b0, 1'b0, 16'h1204}, // R6 R7 word
    {1'b1, 3'd5, 16'h0056, 16'h05C0, 10'd100, 1'b0, 1'b0, 16'h5600}, // R7 odd
    {1'b1, 3'd4, 16'hFF9A, 16'h05C0, 10'd100, 1'b0, 1'b0, 16'h000A}, // R7 even
    {1'b0, 3'd0, 16'hC0F0, 16'h0000, 10'd100, 1'b0, 1'b0, 16'h000A}  // R2 protected
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic b, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_byte = b; acc_addr = a; wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_byte = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1;
  endtask

  task automatic end_read();
    acc_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 tick", 32'(tick_rate), 32'd100);
    chk("R9 display", 32'(display_out), 32'h0);
    chk("R9 force", {30'd0, fie, fnxm}, 32'd0);
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        do_read(3'(s * 2));
        chk("R9 slot clear", 32'(rdata), 32'h0);
        chk("R1 nxm low", 32'(nxm), 32'd0);
        end_read();
      end
    end
    do_read(3'd0); end_read();
    // R1 idle bus reads zero
    chk("R1 idle rdata", 32'(rdata), 32'h0);

    for (int i = 0; i < 14; i++) begin
      logic [63:0] v;
      v = VEC[i];
      do_write(v[63], v[62:60], v[59:44]);
      chk("R5 tick", 32'(tick_rate), 32'(v[27:18]));
      chk("R4 force_ie", 32'(fie), 32'(v[17]));
      chk("R4 force_nxm", 32'(fnxm), 32'(v[16]));
      chk("R7 display", 32'(display_out), 32'(v[15:0]));
      do_read(v[62:60]);
      chk("R2 R3 R6 R8 readback", 32'(rdata), 32'(v[43:28]));
      end_read();
    end

    // R6 different switch pattern
    sw_in = 16'h5A3C;
    do_read(3'd4);
    chk("R6 switch read", 32'(rdata), 32'h0A30);
    end_read();

    // R10 repeated reads leave state unchanged
    do_read(3'd6); end_read();
    do_read(3'd6);
    chk("R10 aux after reads", 32'(rdata), 32'hAB04);
    end_read();
    do_read(3'd4); end_read();
    chk("R10 display after read", 32'(display_out), 32'h000A);
    chk("R10 tick after read", 32'(tick_rate), 32'd100);

    // R1 unimplemented slots on u1
    do_write(1'b0, 3'd2, 16'h1111);
    do_read(3'd2);
    chk("R1 u1 page nxm", 32'(nxm1), 32'd1);
    chk("R1 u1 page zero", 32'(rdata1), 32'h0);
    chk("R1 u0 page ok", 32'(nxm), 32'd0);
    chk("R8 u0 page", 32'(rdata), 32'h1111);
    end_read();
    do_read(3'd7);
    chk("R1 u1 aux nxm", 32'(nxm1), 32'd1);
    chk("R1 u1 aux zero", 32'(rdata1), 32'h0);
    end_read();
    do_write(1'b0, 3'd0, 16'h1000);
    do_read(3'd0);
    chk("R1 u1 csr ok", 32'(nxm1), 32'd0);
    chk("R2 u1 csr", 32'(rdata1), 32'h1000);
    chk("R5 u1 tick", 32'(tick1), 32'd60);
    end_read();

    // R9 reset after activity
    do_write(1'b0, 3'd0, 16'h2C00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 tick after reset", 32'(tick_rate), 32'd100);
    chk("R9 force after reset", {30'd0, fie, fnxm}, 32'd0);
    chk("R9 display after reset", 32'(display_out), 32'h0);
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        do_read(3'(s * 2));
        chk("R9 slot after reset", 32'(rdata), 32'h0);
        end_read();
      end
    end
    finish_run();
  end
endmodule